// File: doc/BRIEF.md
# Packed Halfword Saturating SIMD ALU

This block is a datapath slice that treats each of two 64-bit operands as four packed 16-bit lanes and computes one lane-wise operation per accepted strobe. It offers addition and subtraction with a choice of wraparound, signed clamping or unsigned clamping. It also offers a rounding unsigned average, a shift-then-add with signed clamping, and plain lane shifts in left, arithmetic-right and logical-right forms. Lane 0 occupies bits 15:0 and lane 3 occupies bits 63:48. No carry or borrow crosses from one lane into the next.

A caller presents `op_a`, `op_b`, `opcode` and `shamt` together with `in_vld`. One clock later the result sits in an output register and `res_vld` is high. The result register reloads only on cycles where `in_vld` is high, so an idle cycle leaves the last result in place. The datapath has no state machine. Its single state element is the output register. That register has two conditions: reset, when it holds zero with the valid flag low, and loaded, when it holds the most recent result.

Top module: `hsimd_alu`

## Requirements
- R1: Opcode 0 adds lane by lane modulo 2^16, and a carry out of any lane is discarded rather than passed into the lane above.
- R2: Opcode 1 adds lanes as signed values and clamps each lane to the range 0x8000..0x7FFF.
- R3: Opcode 2 adds lanes as unsigned values, and any lane sum above 0xFFFF gives 0xFFFF.
- R4: Opcode 3 subtracts `op_b` from `op_a` per lane modulo 2^16. Opcode 4 subtracts with signed clamping to 0x8000..0x7FFF. Opcode 5 subtracts as unsigned values and gives 0x0000 whenever the lane of `op_b` exceeds the lane of `op_a`.
- R5: Opcode 6 gives the unsigned average of each lane pair as (a+b+1)>>1, computed on a 17-bit sum so that halves round upward.
- R6: Opcode 7 gives clamp_signed((a<<k)+b) per lane, and opcode 8 gives clamp_signed((a>>>k)+b). Here k is `shamt[1:0]` (0 to 3), `shamt[3:2]` is ignored, and the shift and sum are computed without intermediate loss before the clamp.
- R7: Opcode 9 shifts each lane of `op_a` left, opcode 10 shifts it right arithmetically and opcode 11 shifts it right logically, each by `shamt` (0 to 15). `op_b` is ignored for these opcodes.
- R8: A result appears on `res` exactly one clock after the cycle in which `in_vld` was sampled high, and `res_vld` is high in that cycle and low one clock after any cycle in which `in_vld` was low.
- R9: While `in_vld` is low, `res` keeps its previous value whatever the other inputs do.
- R10: A synchronous active-high `rst` clears `res` to zero and `res_vld` to 0, and it takes priority over a simultaneous `in_vld`.
- R11: Opcodes 12 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and opcode are valid this cycle |
| op_a | input | 64 | First operand, four 16-bit lanes |
| op_b | input | 64 | Second operand, four 16-bit lanes |
| opcode | input | 4 | Operation select (see requirements) |
| shamt | input | 4 | Shift amount; bits 1:0 only for shift-and-add |
| res | output | 64 | Registered lane-wise result |
| res_vld | output | 1 | Result on `res` is new this cycle |

## Verification
Two functions that can fall in the same cycle are clamping (or carry discard) in one lane and ordinary arithmetic in the lane next to it. Every table vector mixes overflowing and non-overflowing lanes in one operand pair, so a carry that leaks across a boundary or a clamp decided on the wrong lane corrupts a neighbour that should be exact. Each vector is judged on the full 64-bit word. A second coincidence is reset arriving together with a valid strobe. The bench raises both in the same cycle and expects a cleared result with the valid flag low.

// File: rtl/hsimd_pkg.sv
package hsimd_pkg;

    typedef enum logic [3:0] {
        OP_ADD_MOD = 4'd0,
        OP_ADD_SS  = 4'd1,
        OP_ADD_US  = 4'd2,
        OP_SUB_MOD = 4'd3,
        OP_SUB_SS  = 4'd4,
        OP_SUB_US  = 4'd5,
        OP_AVG     = 4'd6,
        OP_SHLADD  = 4'd7,
        OP_SHRADD  = 4'd8,
        OP_SHL     = 4'd9,
        OP_SHRA    = 4'd10,
        OP_SHRL    = 4'd11
    } op_e;

endpackage

// File: rtl/hsimd_shift.sv
module hsimd_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic [3:0]   amt,
    input  logic         left,
    input  logic         arith,
    output logic [W-1:0] dout
);

    always_comb begin
        if (left) begin
            dout = din << amt;
        end else if (arith) begin
            dout = W'($signed(din) >>> amt);
        end else begin
            dout = din >> amt;
        end
    end

endmodule

// File: rtl/hsimd_lane.sv
module hsimd_lane
    import hsimd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    input  logic [3:0]   shamt,
    output logic [W-1:0] y
);

    localparam int XW = W + 5;
    localparam logic signed [XW-1:0] SMAX = XW'((64'sd1 <<< (W-1)) - 64'sd1);
    localparam logic signed [XW-1:0] SMIN = -SMAX - XW'(1);

    logic signed [XW-1:0] xa, xb;
    logic [W:0]           usum, udif, uavg;
    logic [1:0]           k;
    logic [W-1:0]         sh_y;
    logic                 sh_left, sh_arith;

    function automatic logic [W-1:0] clamp_s(input logic signed [XW-1:0] v);
        if (v > SMAX) begin
            return {1'b0, {(W-1){1'b1}}};
        end else if (v < SMIN) begin
            return {1'b1, {(W-1){1'b0}}};
        end else begin
            return v[W-1:0];
        end
    endfunction

    assign xa   = {{(XW-W){a[W-1]}}, a};
    assign xb   = {{(XW-W){b[W-1]}}, b};
    assign usum = {1'b0, a} + {1'b0, b};
    assign udif = {1'b0, a} - {1'b0, b};
    assign uavg = usum + (W+1)'(1);
    assign k    = shamt[1:0];

    assign sh_left  = (op == OP_SHL);
    assign sh_arith = (op == OP_SHRA);

    hsimd_shift #(.W(W)) u_shift (
        .din   (a),
        .amt   (shamt),
        .left  (sh_left),
        .arith (sh_arith),
        .dout  (sh_y)
    );

    always_comb begin
        unique case (op)
            OP_ADD_MOD: y = a + b;
            OP_ADD_SS:  y = clamp_s(xa + xb);
            OP_ADD_US:  y = usum[W] ? {W{1'b1}} : usum[W-1:0];
            OP_SUB_MOD: y = a - b;
            OP_SUB_SS:  y = clamp_s(xa - xb);
            OP_SUB_US:  y = udif[W] ? {W{1'b0}} : udif[W-1:0];
            OP_AVG:     y = uavg[W:1];
            OP_SHLADD:  y = clamp_s((xa <<< k) + xb);
            OP_SHRADD:  y = clamp_s((xa >>> k) + xb);
            OP_SHL,
            OP_SHRA,
            OP_SHRL:    y = sh_y;
            default:    y = '0;
        endcase
    end

endmodule

// File: rtl/hsimd_alu.sv
module hsimd_alu
    import hsimd_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_vld,
    input  logic [LANE_W*LANES-1:0]   op_a,
    input  logic [LANE_W*LANES-1:0]   op_b,
    input  logic [3:0]                opcode,
    input  logic [3:0]                shamt,
    output logic [LANE_W*LANES-1:0]   res,
    output logic                      res_vld
);

    localparam int DW = LANE_W * LANES;

    op_e            op;
    logic [DW-1:0]  lane_y;

    assign op = op_e'(opcode);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hsimd_lane #(.W(LANE_W)) u_lane (
            .a     (op_a[g*LANE_W +: LANE_W]),
            .b     (op_b[g*LANE_W +: LANE_W]),
            .op    (op),
            .shamt (shamt),
            .y     (lane_y[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res     <= '0;
            res_vld <= 1'b0;
        end else begin
            res_vld <= in_vld;
            if (in_vld) begin
                res <= lane_y;
            end
        end
    end

endmodule

// File: rtl/hsimd_alu_chk.sv
module hsimd_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_vld,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic [3:0]  opcode,
    input logic [63:0] res,
    input logic        res_vld
);

    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> res_vld);

    // R8
    vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !res_vld);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(res));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (res == 64'd0) && !res_vld);

    // R1
    lane0_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && opcode == 4'd0) |=>
        res[15:0] == 16'($past(op_a[15:0]) + $past(op_b[15:0])));

    // R2
    pos_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && opcode == 4'd1 && !op_a[15] && !op_b[15] &&
         (({1'b0, op_a[15:0]} + {1'b0, op_b[15:0]}) > 17'h07FFF)) |=>
        res[15:0] == 16'h7FFF);

    // R4
    floor_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && opcode == 4'd5 && op_a[15:0] < op_b[15:0]) |=>
        res[15:0] == 16'h0000);

endmodule

bind hsimd_alu hsimd_alu_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .op_a    (op_a),
    .op_b    (op_b),
    .opcode  (opcode),
    .res     (res),
    .res_vld (res_vld)
);

// File: tb/hsimd_alu_test.sv
module hsimd_alu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  opcode = '0;
    logic [3:0]  shamt = '0;
    logic [63:0] res;
    logic        res_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    hsimd_alu uut (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .op_a    (op_a),
        .op_b    (op_b),
        .opcode  (opcode),
        .shamt   (shamt),
        .res     (res),
        .res_vld (res_vld)
    );

    // {req, opcode, shamt, a, b, expected}
    localparam int NV = 16;
    localparam logic [207:0] VEC [NV] = '{
        // R1 carries dropped at every lane edge
        {8'd1,  4'd0,  4'h0, 64'h0001_7FFF_FFFF_8000, 64'h0001_0001_0001_8000, 64'h0002_8000_0000_0000},
        // R2 signed clamp both ends
        {8'd2,  4'd1,  4'h0, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_1111_0001, 64'h7FFF_8000_2345_0000},
        // R3 unsigned clamp
        {8'd3,  4'd2,  4'h0, 64'hFFFF_8000_0001_7FFF, 64'h0001_8000_0002_0001, 64'hFFFF_FFFF_0003_8000},
        // R4 modulo subtract
        {8'd4,  4'd3,  4'h0, 64'h0000_0005_8000_1234, 64'h0001_0003_0001_1234, 64'hFFFF_0002_7FFF_0000},
        // R4 signed subtract
        {8'd4,  4'd4,  4'h0, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0007_8000, 64'h8000_7FFF_FFFE_7FFF},
        // R4 unsigned subtract floors at zero
        {8'd4,  4'd5,  4'h0, 64'h0003_0005_FFFF_0000, 64'h0005_0003_0001_0001, 64'h0000_0002_FFFE_0000},
        // R5 average rounds up
        {8'd5,  4'd6,  4'h0, 64'h0001_FFFF_0004_0000, 64'h0002_FFFF_0005_0000, 64'h0002_FFFF_0005_0000},
        // R6 shift left by 2 then add
        {8'd6,  4'd7,  4'h2, 64'h0001_2000_E000_0010, 64'h0001_0000_0000_0003, 64'h0005_7FFF_8000_0043},
        // R6 shift right by 1 then add
        {8'd6,  4'd8,  4'h1, 64'h0004_8000_FFFF_7FFF, 64'h0001_C000_0000_4000, 64'h0003_8000_FFFF_7FFF},
        // R6 upper shamt bits ignored (0xD -> k=1)
        {8'd6,  4'd7,  4'hD, 64'h0001_0001_0001_4000, 64'h0000_0000_0000_0000, 64'h0002_0002_0002_7FFF},
        // R7 shift left 4, op_b ignored
        {8'd7,  4'd9,  4'h4, 64'h1234_8001_000F_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2340_0010_00F0_FFF0},
        // R7 arithmetic right by 15
        {8'd7,  4'd10, 4'hF, 64'h8000_7FFF_FFFF_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_FFFF_0000},
        // R7 logical right by 4
        {8'd7,  4'd11, 4'h4, 64'h8000_7FFF_FFFF_0010, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0800_07FF_0FFF_0001},
        // R7 shift by zero
        {8'd7,  4'd9,  4'h0, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0},
        // R11 unused opcodes
        {8'd11, 4'd12, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_1111_1111_1111, 64'h0000_0000_0000_0000},
        {8'd11, 4'd15, 4'h3, 64'h7FFF_0001_8000_1234, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000}
    };

    task automatic check(input int req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(10, res, 64'd0);
        check(10, {63'd0, res_vld}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            opcode = VEC[i][199:196];
            shamt  = VEC[i][195:192];
            op_a   = VEC[i][191:128];
            op_b   = VEC[i][127:64];
            in_vld = 1'b1;
            @(negedge clk);
            check(int'(VEC[i][207:200]), res, VEC[i][63:0]);
            // R8 valid flag one cycle later
            check(8, {63'd0, res_vld}, 64'd1);
        end

        // R9 idle cycles keep result while inputs change
        held   = res;
        in_vld = 1'b0;
        opcode = 4'd0;
        op_a   = 64'h1111_2222_3333_4444;
        op_b   = 64'h0101_0101_0101_0101;
        @(negedge clk);
        check(8, {63'd0, res_vld}, 64'd0);
        op_a = 64'hAAAA_BBBB_CCCC_DDDD;
        @(negedge clk);
        check(9, res, held);

        // R8 back-to-back strobes
        in_vld = 1'b1;
        opcode = 4'd0;
        op_a   = 64'h0001_0001_0001_0001;
        op_b   = 64'h0001_0001_0001_0001;
        @(negedge clk);
        check(8, res, 64'h0002_0002_0002_0002);
        opcode = 4'd3;
        @(negedge clk);
        check(8, res, 64'h0000_0000_0000_0000);
        check(8, {63'd0, res_vld}, 64'd1);

        // R10 reset wins over simultaneous strobe
        opcode = 4'd2;
        op_a   = 64'h7777_7777_7777_7777;
        rst    = 1'b1;
        @(negedge clk);
        check(10, res, 64'd0);
        check(10, {63'd0, res_vld}, 64'd0);
        rst    = 1'b0;
        in_vld = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule